// File: doc/BRIEF.md
# Protected Watchdog Timer

This block is a watchdog for a small controller. Software keeps it alive by pulsing a kick strobe. If no kick arrives within the selected number of watchdog-oscillator ticks, the block raises a one-cycle system reset request. It also records the watchdog as the cause in a reset-cause register that the request itself does not clear.

An 8-bit control register holds the enable bit, a 4-bit timeout code, an unlock bit, an interrupt-enable bit and a timeout flag. While the watchdog runs, it cannot be switched off and its timeout cannot be changed by one stray store. Software must first write the unlock bit and the enable bit together. It then commits the new settings with a second write within the next four clocks. While the watchdog is off, the enable bit and the code may be written directly.

Control register bits: 7 timeout flag, 6 interrupt enable, 5 code bit 3, 4 unlock, 3 enable, 2..0 code bits 2..0. Reset-cause bits: 4 debug-port, 3 watchdog, 2 brown-out, 1 external, 0 power-on.

Top module: `wdog_guard`

## Requirements
- R1: After power-on reset (`rst_n` low), `ctl_q` reads 0x00, `cause_q` reads 5'b00001 and `sys_rst_req` is low.
- R2: While enable (bit 3) is 0 and no unlock window is open, a control write with bit 4 clear loads enable from bit 3 and the code from bits {5,2,1,0}. Any control write loads interrupt enable from bit 6.
- R3: While enable is 1 and no window is open, a control write does not clear enable and does not change the code.
- R4: A control write with bits 4 and 3 both set opens an unlock window. Bit 4 reads 1 for the four following cycles. A write with bit 4 clear, sampled on the fourth clock edge after the unlock write, is still accepted and loads enable and the code.
- R5: The window closes after four clocks, after which a write that clears enable is ignored. An accepted commit closes the window at once, so bit 4 reads 0.
- R6: With enable 0, no reset request is issued.
- R7: Only cycles with `wdt_tick` high advance the timeout count. With code c in 0..9 and a tick every cycle, the request rises exactly 2^(BASE_LOG2+c) clock edges after the kick edge.
- R8: Codes 10 to 15 give the same timeout as code 9.
- R9: A `kick` pulse restarts the count from zero, so kicks spaced closer than the timeout prevent any request.
- R10: A timeout gives a `sys_rst_req` pulse exactly one cycle long. In the same cycle, it sets cause bit 3 and control bit 7.
- R11: Writing 1 to control bit 7 clears the timeout flag. Writing 0 to it leaves the flag unchanged.
- R12: A cause write clears each flag whose data bit is 0 and keeps each flag whose data bit is 1. A `cause_evt` bit sets its flag. The flags survive a watchdog reset request, and power-on leaves only bit 0 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wdt_tick | input | 1 | Watchdog oscillator tick, one cycle per tick |
| kick | input | 1 | Restart strobe for the timeout count |
| wr_ctl | input | 1 | Control register write strobe |
| wr_cause | input | 1 | Reset-cause register write strobe |
| wr_data | input | 8 | Write data for both registers |
| cause_evt | input | 5 | Set pulses for the reset-cause flags |
| ctl_q | output | 8 | Control register read value |
| cause_q | output | 5 | Reset-cause register read value |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The assertions take for granted that the shortest timeout spans at least two ticks, so two requests can never be adjacent. They also assume that the reset-cause write strobe never clears the watchdog flag in the cycle the request is raised. The stimulus keeps within both conditions. The bench is built with a base exponent of 4. Every cause write is issued while the watchdog is disabled, or well inside a timeout period just after a kick.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  localparam int CTL_W   = 8;
  localparam int CAUSE_W = 5;
  // control register bit positions
  localparam int B_IF  = 7;
  localparam int B_IE  = 6;
  localparam int B_PS3 = 5;
  localparam int B_CE  = 4;
  localparam int B_EN  = 3;
  // reset-cause bit positions
  localparam int C_WD  = 3;
  localparam int C_POR = 0;
  localparam logic [3:0] CODE_MAX = 4'd9;

  // reserved codes fold onto the longest timeout
  function automatic logic [3:0] eff_code(input logic [3:0] c);
    return (c > CODE_MAX) ? CODE_MAX : c;
  endfunction

  // exponent of the tick count for a given code
  function automatic int timeout_exp(input int base_log2, input logic [3:0] c);
    return base_log2 + int'(eff_code(c));
  endfunction
endpackage

// File: rtl/wdog_ctl_reg.sv
`timescale 1ns/1ps
module wdog_ctl_reg
  import wdog_pkg::*;
#(
  parameter int UNLOCK_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctl,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             expire,
  output logic             en,
  output logic [3:0]       ps,
  output logic             ps_chg,
  output logic             unlock_req,
  output logic             commit,
  output logic [CTL_W-1:0] ctl_q
);
  localparam int WIN_W = $clog2(UNLOCK_CYC + 1);

  logic [WIN_W-1:0] win_cnt;
  logic             win_open, free_wr, ps_load;
  logic             ie_q, irq_q;
  logic [3:0]       ps_new;

  assign win_open   = (win_cnt != '0);
  assign unlock_req = wr_ctl && wr_data[B_CE] && wr_data[B_EN];
  assign commit     = wr_ctl && win_open && !wr_data[B_CE];
  assign free_wr    = wr_ctl && !en && !win_open && !wr_data[B_CE];
  assign ps_load    = commit || free_wr;
  assign ps_new     = {wr_data[B_PS3], wr_data[2:0]};
  assign ps_chg     = ps_load && (ps_new != ps);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      ps      <= '0;
      win_cnt <= '0;
      ie_q    <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (ps_load) begin
        en <= wr_data[B_EN];
        ps <= ps_new;
      end else if (wr_ctl && wr_data[B_EN]) begin
        en <= 1'b1;
      end

      if (unlock_req)    win_cnt <= WIN_W'(UNLOCK_CYC);
      else if (commit)   win_cnt <= '0;
      else if (win_open) win_cnt <= win_cnt - WIN_W'(1);

      if (wr_ctl) ie_q <= wr_data[B_IE];

      if (expire)                     irq_q <= 1'b1;
      else if (wr_ctl && wr_data[B_IF]) irq_q <= 1'b0;
    end
  end

  assign ctl_q = {irq_q, ie_q, ps[3], win_open, en, ps[2:0]};
endmodule

// File: rtl/wdog_counter.sv
`timescale 1ns/1ps
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int BASE_LOG2 = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  input  logic       kick,
  input  logic       clr,
  input  logic [3:0] ps,
  output logic       expire,
  output logic       rst_req
);
  localparam int CW = BASE_LOG2 + int'(CODE_MAX) + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim_m1;

  assign lim_m1 = (CW'(1) << timeout_exp(BASE_LOG2, ps)) - CW'(1);
  assign expire = en && tick && !kick && !clr && (cnt == lim_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= expire;
      if (!en || kick || clr) cnt <= '0;
      else if (tick)          cnt <= expire ? '0 : cnt + CW'(1);
    end
  end
endmodule

// File: rtl/wdog_cause_reg.sv
`timescale 1ns/1ps
module wdog_cause_reg
  import wdog_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_cause,
  input  logic [CAUSE_W-1:0] wr_bits,
  input  logic [CAUSE_W-1:0] cause_evt,
  input  logic               wd_set,
  output logic [CAUSE_W-1:0] cause_q
);
  logic [CAUSE_W-1:0] kept, wd_vec;

  assign kept   = wr_cause ? (cause_q & wr_bits) : cause_q;
  assign wd_vec = wd_set ? (CAUSE_W'(1) << C_WD) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= CAUSE_W'(1) << C_POR;
    else        cause_q <= kept | cause_evt | wd_vec;
  end
endmodule

// File: rtl/wdog_guard.sv
`timescale 1ns/1ps
module wdog_guard
  import wdog_pkg::*;
#(
  parameter int BASE_LOG2  = 11,
  parameter int UNLOCK_CYC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wdt_tick,
  input  logic               kick,
  input  logic               wr_ctl,
  input  logic               wr_cause,
  input  logic [CTL_W-1:0]   wr_data,
  input  logic [CAUSE_W-1:0] cause_evt,
  output logic [CTL_W-1:0]   ctl_q,
  output logic [CAUSE_W-1:0] cause_q,
  output logic               sys_rst_req
);
  logic       wd_en, wd_ps_chg, tmr_expire, unlock_req, commit;
  logic [3:0] wd_ps;

  wdog_ctl_reg #(.UNLOCK_CYC(UNLOCK_CYC)) ctl_i (
    .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wr_data(wr_data),
    .expire(tmr_expire), .en(wd_en), .ps(wd_ps), .ps_chg(wd_ps_chg),
    .unlock_req(unlock_req), .commit(commit), .ctl_q(ctl_q)
  );

  wdog_counter #(.BASE_LOG2(BASE_LOG2)) cnt_i (
    .clk(clk), .rst_n(rst_n), .en(wd_en), .tick(wdt_tick), .kick(kick),
    .clr(wd_ps_chg), .ps(wd_ps), .expire(tmr_expire), .rst_req(sys_rst_req)
  );

  wdog_cause_reg cause_i (
    .clk(clk), .rst_n(rst_n), .wr_cause(wr_cause),
    .wr_bits(wr_data[CAUSE_W-1:0]), .cause_evt(cause_evt),
    .wd_set(tmr_expire), .cause_q(cause_q)
  );
endmodule

module wdog_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_ctl,
  input logic [7:0] wr_data,
  input logic [7:0] ctl_q,
  input logic [4:0] cause_q,
  input logic       sys_rst_req,
  input logic       tmr_expire
);
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> !sys_rst_req); // R10
  AST_REQ_SETS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> (cause_q[3] && ctl_q[7])); // R10
  AST_NO_REQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> $past(ctl_q[3])); // R6
  AST_UNLOCK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_q[4]) |-> $past(wr_ctl && wr_data[4] && wr_data[3])); // R4
  AST_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl_q[3] && !ctl_q[4]) |->
      (ctl_q[3] && ctl_q[5] == $past(ctl_q[5]) && ctl_q[2:0] == $past(ctl_q[2:0]))); // R3
  AST_EXPIRE_TO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_expire |=> sys_rst_req); // R7
endmodule

bind wdog_guard wdog_guard_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wr_data(wr_data),
  .ctl_q(ctl_q), .cause_q(cause_q), .sys_rst_req(sys_rst_req),
  .tmr_expire(tmr_expire)
);

// File: tb/wdog_guard_tb_top.sv
`timescale 1ns/1ps
module wdog_guard_tb_top;
  localparam int BASE = 4;
  localparam int unsigned EXP_TICKS [16] = '{16, 32, 64, 128, 256, 512, 1024,
    2048, 4096, 8192, 8192, 8192, 8192, 8192, 8192, 8192};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wdt_tick = 1'b1;
  logic kick = 1'b0;
  logic wr_ctl = 1'b0;
  logic wr_cause = 1'b0;
  logic [7:0] wr_data = '0;
  logic [4:0] cause_evt = '0;
  logic [7:0] ctl_q;
  logic [4:0] cause_q;
  logic sys_rst_req;

  int checks = 0;
  int errors = 0;
  int req_cnt = 0;

  always #2.5 clk = ~clk;

  wdog_guard #(.BASE_LOG2(BASE), .UNLOCK_CYC(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .wdt_tick(wdt_tick), .kick(kick),
    .wr_ctl(wr_ctl), .wr_cause(wr_cause), .wr_data(wr_data),
    .cause_evt(cause_evt), .ctl_q(ctl_q), .cause_q(cause_q),
    .sys_rst_req(sys_rst_req)
  );

  always @(posedge clk) if (sys_rst_req) req_cnt <= req_cnt + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wctl(input logic [7:0] d);
    @(negedge clk); wr_ctl = 1'b1; wr_data = d;
    @(posedge clk); #1 wr_ctl = 1'b0;
  endtask

  task automatic wcause(input logic [7:0] d);
    @(negedge clk); wr_cause = 1'b1; wr_data = d;
    @(posedge clk); #1 wr_cause = 1'b0;
  endtask

  task automatic kickp();
    @(negedge clk); kick = 1'b1;
    @(posedge clk); #1 kick = 1'b0;
  endtask

  task automatic measure(output int n);
    n = 0;
    for (int k = 0; k < 20000; k++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (sys_rst_req) break;
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    int n, base_req;
    idle(3);
    // R1 reset state
    check("R1 ctl", ctl_q, 8'h00);
    check("R1 cause", cause_q, 5'b00001);
    check("R1 req", sys_rst_req, 0);
    rst_n = 1'b1;
    idle(2);

    // R2 direct write while disabled
    wctl(8'h4F);
    check("R2 free write", ctl_q, 8'h4F);
    // R3 locked: clear and code change ignored, IE still written
    wctl(8'h40);
    check("R3 clear ignored", ctl_q, 8'h4F);
    wctl(8'h2A);
    check("R3 code ignored, R2 IE", ctl_q, 8'h0F);

    // R4 unlock, commit on the fourth edge
    wctl(8'h18);
    check("R4 unlock bit", ctl_q, 8'h1F);
    idle(3);
    check("R4 window still open", ctl_q[4], 1);
    wctl(8'h0B);
    check("R4 late commit", ctl_q, 8'h0B);

    // R5 window expiry
    wctl(8'h18);
    idle(4);
    check("R5 window closed", ctl_q[4], 0);
    wctl(8'h00);
    check("R5 late clear ignored", ctl_q, 8'h0B);

    // R6 disable via unlock, then no requests
    wctl(8'h18);
    wctl(8'h00);
    check("R6 disabled", ctl_q, 8'h00);
    base_req = req_cnt;
    idle(300);
    check("R6 no request", req_cnt - base_req, 0);

    // R9 kicks keep the shortest timeout from expiring
    wctl(8'h08);
    check("R2 enable code 0", ctl_q, 8'h08);
    base_req = req_cnt;
    for (int k = 0; k < 12; k++) begin
      kickp();
      idle(8);
    end
    check("R9 kicked, no request", req_cnt - base_req, 0);

    // R7 no ticks, no progress
    wdt_tick = 1'b0;
    kickp();
    base_req = req_cnt;
    idle(100);
    check("R7 tick gating", req_cnt - base_req, 0);
    wdt_tick = 1'b1;

    // R7/R8 timeout per code
    for (int i = 0; i < 16; i++) begin
      logic [3:0] c;
      c = 4'(i);
      wctl(8'h18);
      wctl({2'b00, c[3], 1'b0, 1'b1, c[2:0]});
      check(i < 10 ? "R7 code loaded" : "R8 code loaded",
            ctl_q & 8'h3F, {2'b00, c[3], 1'b0, 1'b1, c[2:0]});
      kickp();
      measure(n);
      check(i < 10 ? "R7 timeout length" : "R8 reserved timeout", n, EXP_TICKS[i]);
    end

    // R10 pulse and flags
    wctl(8'h18);
    wctl(8'h08);
    wcause(8'h00);
    check("R12 cleared by zeros", cause_q, 5'b00000);
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (sys_rst_req) break;
    end
    check("R10 request seen", sys_rst_req, 1);
    check("R10 watchdog flag", cause_q, 5'b01000);
    check("R10 timeout flag", ctl_q[7], 1);
    idle(1);
    check("R10 one cycle", sys_rst_req, 0);

    // R11 timeout flag write rules
    kickp();
    wctl(8'h08);
    check("R11 write 0 keeps", ctl_q, 8'h88);
    wctl(8'h88);
    check("R11 write 1 clears", ctl_q, 8'h08);

    // R12 cause register
    wctl(8'h18);
    wctl(8'h00);
    check("R12 flag persists", cause_q[3], 1);
    wcause(8'h00);
    @(negedge clk); cause_evt = 5'b10110;
    @(posedge clk); #1 cause_evt = '0;
    check("R12 event sets", cause_q, 5'b10110);
    wcause(8'h13);
    check("R12 ones keep", cause_q, 5'b10010);
    rst_n = 1'b0;
    idle(2);
    check("R12 power-on", cause_q, 5'b00001);
    check("R1 ctl after power-on", ctl_q, 8'h00);

    summary();
    $finish;
  end
endmodule